// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the combinational arithmetic-logic unit of a small 8/16-bit accumulator machine. Each cycle it takes five inputs: the 16-bit accumulator A, the 16-bit temporary register T, one 8-bit operand byte (from a register, an immediate or memory), the current carry flag and an operation code. From these it returns the value to write back and new values for the negative, zero, overflow and carry flags. Each flag comes with its own write enable, so the surrounding flag register changes only the flags the operation defines.

The operations are: add and subtract with carry, in byte and word width; increment and decrement; bitwise AND, OR and XOR; compare; rotate through carry; and decimal correction after addition or subtraction. Several operations take T as the minuend and A as the subtrahend. Byte operations leave the high byte of A as it is. Decoding, addressing and multiply/divide are handled elsewhere.

Top module: `acc_alu_top`

## Requirements
- R1: `op_i` encodes: 0 ADD_B, 1 SUB_B, 2 ADD_W, 3 SUB_W, 4 ADD_T, 5 SUB_T, 6 INC_B, 7 DEC_B, 8 INC_W, 9 DEC_W, 10 AND_B, 11 OR_B, 12 XOR_B, 13 AND_W, 14 OR_W, 15 XOR_W, 16 CMP_B, 17 CMP_T, 18 CMP_W, 19 ROLC, 20 RORC, 21 DAA, 22 DAS. Codes 23 to 31 return A unchanged, with all flag enables low.
- R2: ADD_B gives AL + operand + C and SUB_B gives AL − operand − C. Both update all four flags.
- R3: ADD_W gives A + T + C and SUB_W gives T − A − C. Both write the full 16-bit result and update all four flags, taken at bit 15.
- R4: ADD_T gives AL + TL + C and SUB_T gives TL − AL − C. Both update all four flags.
- R5: INC_B and DEC_B return operand ± 1 in the low byte. They update N, Z and V. C is not enabled.
- R6: INC_W and DEC_W return A ± 1 over 16 bits. Only N and Z are enabled.
- R7: The byte logic operations combine AL with the operand. The word logic operations combine A with T. They enable N, Z and V, with V forced to 0. C is not enabled.
- R8: CMP_B forms AL − operand, CMP_T forms TL − AL and CMP_W forms T − A, each with no incoming carry. All four flags come from the difference. The result output equals A.
- R9: ROLC gives {AL[6:0], C} with new C = AL[7]. RORC gives {C, AL[7:1]} with new C = AL[0]. N, Z and C are enabled and V is not.
- R10: DAA adds an adjustment to AL. The adjustment includes 0x06 when AL[3:0] > 9. It includes 0x60 when C = 1 or AL > 0x99. The new C is C OR (AL > 0x99). V is signed overflow of the addition. All four flags are enabled.
- R11: DAS subtracts an adjustment from AL. The adjustment includes 0x06 when AL[3:0] > 9 and 0x60 when C = 1. The new C equals the incoming C. V is signed overflow of the subtraction. All four flags are enabled.
- R12: N is the top bit of the flag source at the operation width (bit 7 or bit 15). Z is set when that value is zero. V is signed overflow. For subtraction, C means a borrow occurred. A flag whose enable is low reads 0, except `c_o`, which then equals `c_i`.
- R13: Every byte-width operation (R2, R4, R5, R7 byte forms, R9, R10, R11) returns A[15:8] unchanged in `res_o[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Accumulator A |
| t_i | input | 16 | Temporary register T |
| opnd_i | input | 8 | Operand byte (register, immediate or memory) |
| c_i | input | 1 | Incoming carry flag |
| op_i | input | 5 | Operation code, encoded as in R1 |
| res_o | output | 16 | Value to write back to A or to the operand register |
| n_o | output | 1 | Negative flag value |
| z_o | output | 1 | Zero flag value |
| v_o | output | 1 | Overflow flag value |
| c_o | output | 1 | Carry/borrow flag value |
| n_we_o | output | 1 | Negative flag update enable |
| z_we_o | output | 1 | Zero flag update enable |
| v_we_o | output | 1 | Overflow flag update enable |
| c_we_o | output | 1 | Carry flag update enable |

## Verification
The assertions check the structural rules on every evaluation:
- the high byte is kept in byte operations;
- compares do not alter A;
- logic operations force V low and leave C alone;
- word increment and decrement and the rotates leave V (and, where stated, C) disabled;
- `c_o` follows `c_i` whenever C is not enabled;
- unused codes do nothing.

Only the bench's sweeps can show that the computed values are correct. These cover the sums and differences with their operand order, the carry and borrow values, the overflow at bits 7 and 15, and the decimal-correction results. The sweeps run every AL value against a set of operand bytes and both carry values, plus patterned and corner word pairs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OP_W   = 5;
    localparam int NIB_W  = BYTE_W / 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_B = 5'd0,
        OP_SUB_B = 5'd1,
        OP_ADD_W = 5'd2,
        OP_SUB_W = 5'd3,
        OP_ADD_T = 5'd4,
        OP_SUB_T = 5'd5,
        OP_INC_B = 5'd6,
        OP_DEC_B = 5'd7,
        OP_INC_W = 5'd8,
        OP_DEC_W = 5'd9,
        OP_AND_B = 5'd10,
        OP_OR_B  = 5'd11,
        OP_XOR_B = 5'd12,
        OP_AND_W = 5'd13,
        OP_OR_W  = 5'd14,
        OP_XOR_W = 5'd15,
        OP_CMP_B = 5'd16,
        OP_CMP_T = 5'd17,
        OP_CMP_W = 5'd18,
        OP_ROLC  = 5'd19,
        OP_RORC  = 5'd20,
        OP_DAA   = 5'd21,
        OP_DAS   = 5'd22
    } op_e;

    // flag bundle: negative, zero, overflow, carry
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flag_t;

    // operand set presented to one adder lane
    typedef struct packed {
        word_t x;
        word_t y;
        logic  sub;
        logic  cin;
    } lane_in_t;

    localparam flag_t WE_ALL  = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
    localparam flag_t WE_NZV  = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
    localparam flag_t WE_NZ   = '{n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b0};
    localparam flag_t WE_NZC  = '{n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b1};
    localparam flag_t WE_NONE = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    function automatic lane_in_t mk_lane(word_t x, word_t y, logic sub, logic cin);
        lane_in_t l;
        l.x   = x;
        l.y   = y;
        l.sub = sub;
        l.cin = cin;
        return l;
    endfunction

    // nibble above decimal range
    function automatic logic nib_over(logic [NIB_W-1:0] nib);
        return nib > NIB_W'(9);
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         ovf_o
);
    logic [W-1:0] y_eff;
    logic         c_eff;
    logic [W:0]   full;

    always_comb begin
        // subtract as x + ~y + ~borrow; carry out inverted is the borrow
        y_eff = sub_i ? ~y_i : y_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
        sum_o = full[W-1:0];
        cy_o  = sub_i ? ~full[W] : full[W];
        ovf_o = (x_i[W-1] == y_eff[W-1]) && (sum_o[W-1] != x_i[W-1]);
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  op_e   op_i,
    input  word_t a_i,
    input  word_t t_i,
    input  byte_t opnd_i,
    input  logic  c_i,
    output word_t res_o,
    output logic  rot_c_o
);
    byte_t al;
    byte_t ah;

    always_comb begin
        al      = a_i[BYTE_W-1:0];
        ah      = a_i[WORD_W-1:BYTE_W];
        res_o   = a_i;
        rot_c_o = c_i;
        unique case (op_i)
            OP_AND_B: res_o = {ah, al & opnd_i};
            OP_OR_B:  res_o = {ah, al | opnd_i};
            OP_XOR_B: res_o = {ah, al ^ opnd_i};
            OP_AND_W: res_o = a_i & t_i;
            OP_OR_W:  res_o = a_i | t_i;
            OP_XOR_W: res_o = a_i ^ t_i;
            OP_ROLC: begin
                res_o   = {ah, al[BYTE_W-2:0], c_i};
                rot_c_o = al[BYTE_W-1];
            end
            OP_RORC: begin
                res_o   = {ah, c_i, al[BYTE_W-1:1]};
                rot_c_o = al[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
    import acc_alu_pkg::*;
(
    input  byte_t al_i,
    input  logic  c_i,
    input  logic  sub_i,
    output byte_t res_o,
    output logic  cy_o,
    output logic  ovf_o
);
    localparam byte_t LO_FIX  = byte_t'(8'h06);
    localparam byte_t HI_FIX  = byte_t'(8'h60);
    localparam byte_t DEC_MAX = byte_t'(8'h99);

    byte_t adj;
    logic  hi_need;

    always_comb begin
        hi_need = sub_i ? c_i : (c_i || (al_i > DEC_MAX));
        adj     = (nib_over(al_i[NIB_W-1:0]) ? LO_FIX : '0)
                | (hi_need ? HI_FIX : '0);
        res_o   = sub_i ? (al_i - adj) : (al_i + adj);
        cy_o    = hi_need;
        // adj never has its top bit set
        ovf_o   = sub_i ? ( al_i[BYTE_W-1] && !res_o[BYTE_W-1])
                        : (!al_i[BYTE_W-1] &&  res_o[BYTE_W-1]);
    end
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import acc_alu_pkg::*;
(
    input  logic [15:0] a_i,
    input  logic [15:0] t_i,
    input  logic [7:0]  opnd_i,
    input  logic        c_i,
    input  logic [4:0]  op_i,
    output logic [15:0] res_o,
    output logic        n_o,
    output logic        z_o,
    output logic        v_o,
    output logic        c_o,
    output logic        n_we_o,
    output logic        z_we_o,
    output logic        v_we_o,
    output logic        c_we_o
);
    localparam int LANES = 2;

    op_e      op;
    byte_t    al;
    byte_t    ah;
    byte_t    tl;
    lane_in_t lane_b;
    lane_in_t lane_w;

    word_t byte_res;
    logic  byte_cy;
    logic  byte_ov;
    word_t word_res;
    logic  word_cy;
    logic  word_ov;

    word_t lg_res;
    logic  lg_c;
    byte_t dec_res;
    logic  dec_c;
    logic  dec_v;

    word_t res;
    word_t src;
    logic  wide;
    logic  v_val;
    logic  c_val;
    flag_t we;

    assign op = op_e'(op_i);
    assign al = a_i[BYTE_W-1:0];
    assign ah = a_i[WORD_W-1:BYTE_W];
    assign tl = t_i[BYTE_W-1:0];

    // operand steering for both adder lanes
    always_comb begin
        lane_b = mk_lane(word_t'(al), word_t'(opnd_i), 1'b0, 1'b0);
        lane_w = mk_lane(a_i, t_i, 1'b0, 1'b0);
        unique case (op)
            OP_ADD_B: lane_b = mk_lane(word_t'(al), word_t'(opnd_i), 1'b0, c_i);
            OP_SUB_B: lane_b = mk_lane(word_t'(al), word_t'(opnd_i), 1'b1, c_i);
            OP_ADD_T: lane_b = mk_lane(word_t'(al), word_t'(tl), 1'b0, c_i);
            OP_SUB_T: lane_b = mk_lane(word_t'(tl), word_t'(al), 1'b1, c_i);
            OP_INC_B: lane_b = mk_lane(word_t'(opnd_i), word_t'(1), 1'b0, 1'b0);
            OP_DEC_B: lane_b = mk_lane(word_t'(opnd_i), word_t'(1), 1'b1, 1'b0);
            OP_CMP_B: lane_b = mk_lane(word_t'(al), word_t'(opnd_i), 1'b1, 1'b0);
            OP_CMP_T: lane_b = mk_lane(word_t'(tl), word_t'(al), 1'b1, 1'b0);
            OP_ADD_W: lane_w = mk_lane(a_i, t_i, 1'b0, c_i);
            OP_SUB_W: lane_w = mk_lane(t_i, a_i, 1'b1, c_i);
            OP_INC_W: lane_w = mk_lane(a_i, word_t'(1), 1'b0, 1'b0);
            OP_DEC_W: lane_w = mk_lane(a_i, word_t'(1), 1'b1, 1'b0);
            OP_CMP_W: lane_w = mk_lane(t_i, a_i, 1'b1, 1'b0);
            default: ;
        endcase
    end

    // one adder per width: lane 0 is byte wide, lane 1 word wide
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = BYTE_W << g;
        logic [LW-1:0] x;
        logic [LW-1:0] y;
        logic [LW-1:0] s;
        logic          sb;
        logic          ci;
        logic          cy;
        logic          ov;

        if (LW < WORD_W) begin : g_narrow
            assign x  = lane_b.x[LW-1:0];
            assign y  = lane_b.y[LW-1:0];
            assign sb = lane_b.sub;
            assign ci = lane_b.cin;
            assign byte_res = {a_i[WORD_W-1:LW], s};
            assign byte_cy  = cy;
            assign byte_ov  = ov;
        end else begin : g_full
            assign x  = lane_w.x;
            assign y  = lane_w.y;
            assign sb = lane_w.sub;
            assign ci = lane_w.cin;
            assign word_res = s;
            assign word_cy  = cy;
            assign word_ov  = ov;
        end

        acc_alu_addsub #(.W(LW)) u_add (
            .x_i   (x),
            .y_i   (y),
            .sub_i (sb),
            .cin_i (ci),
            .sum_o (s),
            .cy_o  (cy),
            .ovf_o (ov)
        );
    end

    acc_alu_logic u_logic (
        .op_i    (op),
        .a_i     (a_i),
        .t_i     (t_i),
        .opnd_i  (opnd_i),
        .c_i     (c_i),
        .res_o   (lg_res),
        .rot_c_o (lg_c)
    );

    acc_alu_decadj u_dec (
        .al_i  (al),
        .c_i   (c_i),
        .sub_i (op == OP_DAS),
        .res_o (dec_res),
        .cy_o  (dec_c),
        .ovf_o (dec_v)
    );

    // result and flag selection per operation
    always_comb begin
        res   = a_i;
        src   = a_i;
        wide  = 1'b0;
        v_val = 1'b0;
        c_val = c_i;
        we    = WE_NONE;
        unique case (op)
            OP_ADD_B, OP_SUB_B, OP_ADD_T, OP_SUB_T: begin
                res = byte_res; src = byte_res;
                v_val = byte_ov; c_val = byte_cy; we = WE_ALL;
            end
            OP_INC_B, OP_DEC_B: begin
                res = byte_res; src = byte_res;
                v_val = byte_ov; we = WE_NZV;
            end
            OP_ADD_W, OP_SUB_W: begin
                res = word_res; src = word_res; wide = 1'b1;
                v_val = word_ov; c_val = word_cy; we = WE_ALL;
            end
            OP_INC_W, OP_DEC_W: begin
                res = word_res; src = word_res; wide = 1'b1;
                we = WE_NZ;
            end
            OP_AND_B, OP_OR_B, OP_XOR_B: begin
                res = lg_res; src = lg_res; we = WE_NZV;
            end
            OP_AND_W, OP_OR_W, OP_XOR_W: begin
                res = lg_res; src = lg_res; wide = 1'b1; we = WE_NZV;
            end
            OP_CMP_B, OP_CMP_T: begin
                src = byte_res; v_val = byte_ov; c_val = byte_cy; we = WE_ALL;
            end
            OP_CMP_W: begin
                src = word_res; wide = 1'b1;
                v_val = word_ov; c_val = word_cy; we = WE_ALL;
            end
            OP_ROLC, OP_RORC: begin
                res = lg_res; src = lg_res; c_val = lg_c; we = WE_NZC;
            end
            OP_DAA, OP_DAS: begin
                res = {ah, dec_res}; src = {ah, dec_res};
                v_val = dec_v; c_val = dec_c; we = WE_ALL;
            end
            default: ;
        endcase
    end

    assign res_o  = res;
    assign n_o    = we.n & (wide ? src[WORD_W-1] : src[BYTE_W-1]);
    assign z_o    = we.z & (wide ? (src == '0) : (src[BYTE_W-1:0] == '0));
    assign v_o    = we.v & v_val;
    assign c_o    = we.c ? c_val : c_i;
    assign n_we_o = we.n;
    assign z_we_o = we.z;
    assign v_we_o = we.v;
    assign c_we_o = we.c;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic [15:0] a_i,
    input logic [4:0]  op_i,
    input logic        c_i,
    input logic [15:0] res_o,
    input logic        v_o,
    input logic        c_o,
    input logic        n_we_o,
    input logic        z_we_o,
    input logic        v_we_o,
    input logic        c_we_o
);
    logic is_byte;
    logic is_logic;
    logic is_cmp;

    always_comb begin
        is_byte  = op_i inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd10,
                                5'd11, 5'd12, 5'd19, 5'd20, 5'd21, 5'd22};
        is_logic = op_i inside {[5'd10:5'd15]};
        is_cmp   = op_i inside {[5'd16:5'd18]};

        // R13
        ah_keep_chk: assert (!is_byte || (res_o[15:8] == a_i[15:8]))
            else $error("high byte altered by byte op %0d", op_i);
        // R7
        logic_flag_chk: assert (!is_logic || (v_we_o && !v_o && !c_we_o))
            else $error("logic op %0d flag rule broken", op_i);
        // R8
        cmp_keep_chk: assert (!is_cmp || ((res_o == a_i) && c_we_o && v_we_o))
            else $error("compare op %0d altered result or flags", op_i);
        // R6
        incw_flag_chk: assert (!(op_i inside {5'd8, 5'd9}) || (!v_we_o && !c_we_o && n_we_o && z_we_o))
            else $error("word inc/dec enables wrong");
        // R9
        rot_flag_chk: assert (!(op_i inside {5'd19, 5'd20}) || (!v_we_o && c_we_o))
            else $error("rotate enables wrong");
        // R12
        c_hold_chk: assert (c_we_o || (c_o == c_i))
            else $error("carry changed while not enabled");
        // R1
        undef_op_chk: assert ((op_i < 5'd23) ||
                              ((res_o == a_i) && !n_we_o && !z_we_o && !v_we_o && !c_we_o))
            else $error("undefined code %0d had an effect", op_i);
    end
endmodule

bind acc_alu_top acc_alu_chk chk_i (
    .a_i    (a_i),
    .op_i   (op_i),
    .c_i    (c_i),
    .res_o  (res_o),
    .v_o    (v_o),
    .c_o    (c_o),
    .n_we_o (n_we_o),
    .z_we_o (z_we_o),
    .v_we_o (v_we_o),
    .c_we_o (c_we_o)
);

// File: tb/acc_alu_top_tb_top.sv
`timescale 1ns/1ps
module acc_alu_top_tb_top;
    import acc_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_s = '0;
    logic [15:0] t_s = '0;
    logic [7:0]  o_s = '0;
    logic        c_s = 1'b0;
    logic [4:0]  op_s = 5'd31;
    logic [15:0] res_w;
    logic        n_w, z_w, v_w, c_w, nwe_w, zwe_w, vwe_w, cwe_w;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu_top dut_i (
        .a_i(a_s), .t_i(t_s), .opnd_i(o_s), .c_i(c_s), .op_i(op_s),
        .res_o(res_w), .n_o(n_w), .z_o(z_w), .v_o(v_w), .c_o(c_w),
        .n_we_o(nwe_w), .z_we_o(zwe_w), .v_we_o(vwe_w), .c_we_o(cwe_w)
    );

    // returns {carry, overflow, 16-bit result} computed arithmetically
    function automatic logic [17:0] arith(int x, int y, int ci, bit sub, int w);
        int s, r, msk, tb;
        bit cy, ov, sx, sy, sr;
        msk = (1 << w) - 1;
        tb  = w - 1;
        s   = sub ? (x - y - ci) : (x + y + ci);
        r   = s & msk;
        cy  = sub ? (s < 0) : (s > msk);
        sx  = ((x >> tb) & 1) != 0;
        sy  = ((y >> tb) & 1) != 0;
        sr  = ((r >> tb) & 1) != 0;
        ov  = sub ? ((sx != sy) && (sr != sx)) : ((sx == sy) && (sr != sx));
        return {cy, ov, 16'(r)};
    endfunction

    function automatic string req_of(int op);
        case (op)
            0, 1:          return "R2 R12 R13";
            2, 3:          return "R3 R12";
            4, 5:          return "R4 R12 R13";
            6, 7:          return "R5 R12 R13";
            8, 9:          return "R6 R12";
            10, 11, 12:    return "R7 R12 R13";
            13, 14, 15:    return "R7 R12";
            16, 17, 18:    return "R8 R12";
            19, 20:        return "R9 R12 R13";
            21:            return "R10 R12 R13";
            22:            return "R11 R12 R13";
            default:       return "R1";
        endcase
    endfunction

    // expected {res, n, z, v, c, nwe, zwe, vwe, cwe}
    function automatic logic [23:0] model(int op, int a, int t, int o, int c);
        int al, ah, tl, r, src, w, adj;
        logic [17:0] q;
        bit fv, fc;
        bit [3:0] we;
        al = a & 255; ah = a >> 8; tl = t & 255;
        r = a; src = a; w = 8; fv = 0; fc = c; we = 4'b0000;
        case (op)
            0:  begin q = arith(al, o, c, 0, 8);  we = 4'b1111; end
            1:  begin q = arith(al, o, c, 1, 8);  we = 4'b1111; end
            2:  begin q = arith(a, t, c, 0, 16);  we = 4'b1111; w = 16; end
            3:  begin q = arith(t, a, c, 1, 16);  we = 4'b1111; w = 16; end
            4:  begin q = arith(al, tl, c, 0, 8); we = 4'b1111; end
            5:  begin q = arith(tl, al, c, 1, 8); we = 4'b1111; end
            6:  begin q = arith(o, 1, 0, 0, 8);   we = 4'b1110; end
            7:  begin q = arith(o, 1, 0, 1, 8);   we = 4'b1110; end
            8:  begin q = arith(a, 1, 0, 0, 16);  we = 4'b1100; w = 16; end
            9:  begin q = arith(a, 1, 0, 1, 16);  we = 4'b1100; w = 16; end
            16: begin q = arith(al, o, 0, 1, 8);  we = 4'b1111; end
            17: begin q = arith(tl, al, 0, 1, 8); we = 4'b1111; end
            18: begin q = arith(t, a, 0, 1, 16);  we = 4'b1111; w = 16; end
            default: q = '0;
        endcase
        if (op <= 9 || (op >= 16 && op <= 18)) begin
            src = int'(q[15:0]);
            fv = q[16];
            if (we[0]) fc = q[17];
            if (op >= 16) r = a;
            else if (w == 8) r = (ah << 8) | src;
            else r = src;
        end
        case (op)
            10: begin src = al & o; we = 4'b1110; end
            11: begin src = al | o; we = 4'b1110; end
            12: begin src = al ^ o; we = 4'b1110; end
            13: begin src = a & t; we = 4'b1110; w = 16; end
            14: begin src = a | t; we = 4'b1110; w = 16; end
            15: begin src = a ^ t; we = 4'b1110; w = 16; end
            19: begin src = ((al << 1) & 255) | c; fc = (al >> 7) & 1; we = 4'b1101; end
            20: begin src = (c << 7) | (al >> 1); fc = al & 1; we = 4'b1101; end
            21: begin
                adj = (((al & 15) > 9) ? 6 : 0) + ((c != 0 || al > 153) ? 96 : 0);
                src = (al + adj) & 255;
                fc  = (c != 0) || (al > 153);
                fv  = (al < 128) && (src >= 128);
                we  = 4'b1111;
            end
            22: begin
                adj = (((al & 15) > 9) ? 6 : 0) + ((c != 0) ? 96 : 0);
                src = (al - adj) & 255;
                fc  = c != 0;
                fv  = (al >= 128) && (src < 128);
                we  = 4'b1111;
            end
            default: ;
        endcase
        if (op >= 10 && op <= 15) fv = 0;
        if ((op >= 10 && op <= 15) || (op >= 19 && op <= 22))
            r = (w == 16) ? src : ((ah << 8) | src);
        if (!we[1]) fv = 0;
        if (!we[0]) fc = c;
        return {16'(r),
                we[3] && (((src >> (w - 1)) & 1) != 0),
                we[2] && ((src & ((1 << w) - 1)) == 0),
                fv, fc, we};
    endfunction

    task automatic apply(int op, int a, int t, int o, int c);
        logic [23:0] exp_v, got_v;
        @(posedge clk);
        #1;
        op_s = 5'(op); a_s = 16'(a); t_s = 16'(t); o_s = 8'(o); c_s = c[0];
        #2;
        exp_v = model(op, a, t, o, c);
        got_v = {res_w, n_w, z_w, v_w, c_w, nwe_w, zwe_w, vwe_w, cwe_w};
        n_cmp++;
        if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h t=%h o=%h c=%0d actual=%h expected=%h",
                     req_of(op), op, a, t, o, c, got_v, exp_v);
        end
    endtask

    int ovals[12] = '{8'h00, 8'h01, 8'h09, 8'h0F, 8'h10, 8'h55,
                      8'h7F, 8'h80, 8'h99, 8'h9A, 8'hF0, 8'hFF};
    int bops[15]  = '{0, 1, 4, 5, 6, 7, 10, 11, 12, 16, 17, 19, 20, 21, 22};
    int wops[8]   = '{2, 3, 8, 9, 13, 14, 15, 18};
    int wcorn[5]  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

    initial begin
        // R1: output state during reset with an undefined code
        repeat (2) apply(31, 16'h1234, 16'hABCD, 8'h5A, 1);
        rst = 1'b0;
        // R1: every unused code is a pass-through
        for (int op = 23; op < 32; op++)
            for (int k = 0; k < 40; k++)
                apply(op, (k * 40503) & 16'hFFFF, (k * 27459) & 16'hFFFF, k * 7 & 255, k & 1);
        // byte-wide operations: every AL against a set of operand bytes
        foreach (bops[i])
            for (int al = 0; al < 256; al++)
                for (int k = 0; k < 12; k++)
                    for (int c = 0; c < 2; c++)
                        apply(bops[i], ((al ^ 8'h5A) << 8) | al,
                              ((k * 13 & 255) << 8) | ovals[k], ovals[k], c);
        // word-wide operations: patterned pairs and boundary pairs
        foreach (wops[i]) begin
            for (int k = 0; k < 1024; k++)
                for (int c = 0; c < 2; c++)
                    apply(wops[i], ((k * 40503) ^ (k >> 3)) & 16'hFFFF,
                          (k * 27459 + 16'h7FFF) & 16'hFFFF, k & 255, c);
            foreach (wcorn[x])
                foreach (wcorn[y])
                    for (int c = 0; c < 2; c++)
                        apply(wops[i], wcorn[x], wcorn[y], 8'h00, c);
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule